// File: doc/BRIEF.md
# Host Parallel Handshake Port

This block is a byte-wide slave port through which an external host processor moves data to and from an embedded controller. The host sees an 8-bit data path, a read/write select, a strobe and two active-low ready flags: one says the controller can accept a byte from the host, the other says a byte is waiting for the host. The controller side has two arm bits, an output data register it loads, an input data register it reads, and two single-cycle completion interrupts.

The controller arms a direction by driving its arm bit low, then high, then low again. The falling edge of that pulse pulls the matching ready flag low. The host then holds read/write at the level for that direction and pulses strobe high-low-high. All host controls are resynchronised into the controller clock, and the strobe's rising edge completes the cycle. On that edge the flag returns high, a host write latches the bus into the input register, and the interrupt for that direction fires for one clock. A strobe aimed at a direction that is not armed does nothing.

The output bus is modelled as a data vector plus a drive enable, which the pad ring turns into a three-state pin. The enable is high only while the host reads an armed byte with strobe low. At all other times the pins float.

Top module: `host_slave_port`

## Requirements
- R1: After a synchronous reset, host_in_rdy_n and host_out_rdy_n are 1, both interrupts are 0, host_dout_en is 0, host_dout is 0 and ctl_idata is 0. The same holds after a reset applied in the middle of an armed cycle.
- R2: A 1-to-0 transition of ctl_arm_wr drives host_in_rdy_n to 0, and a 1-to-0 transition of ctl_arm_rd drives host_out_rdy_n to 0. A 0-to-1 transition of either bit, or holding it at 1, leaves its flag unchanged.
- R3: With host_in_rdy_n at 0 and host_rnw at 0, the strobe's rising edge stores host_din into ctl_idata and returns host_in_rdy_n to 1 within six controller clocks.
- R4: A completed write raises irq_wr_done for exactly one clock, in the same clock that host_in_rdy_n returns to 1.
- R5: With host_out_rdy_n at 0 and host_rnw at 1, the strobe's rising edge returns host_out_rdy_n to 1 and raises irq_rd_done for exactly one clock. irq_wr_done stays 0.
- R6: host_dout_en is 1 only while host_rnw is 1, host_strobe is 0 and host_out_rdy_n is 0, as seen through the synchroniser plus one register. While host_dout_en is 1, host_dout equals the byte last loaded with ctl_odata_we. Otherwise host_dout is 0.
- R7: A strobe for a direction whose flag is 1 (not armed) changes neither flag, raises no interrupt, leaves ctl_idata unchanged and leaves host_dout_en at 0.
- R8: A read strobe (host_rnw at 1) issued while only the write direction is armed leaves host_in_rdy_n at 0. A later write strobe then still completes normally.
- R9: ctl_idata holds its value until the next completed write, through any number of reads and ignored strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| host_din | input | DATA_W | Byte driven by the host during a write |
| host_rnw | input | 1 | Host direction select: 1 for read, 0 for write |
| host_strobe | input | 1 | Host strobe, idle high, active-low pulse |
| host_dout | output | DATA_W | Byte presented to the host during a read |
| host_dout_en | output | 1 | Drive enable for host_dout pins |
| host_in_rdy_n | output | 1 | Active-low: controller ready to take a host write |
| host_out_rdy_n | output | 1 | Active-low: byte ready for the host to read |
| ctl_arm_wr | input | 1 | Controller arm bit for the write direction (falling edge arms) |
| ctl_arm_rd | input | 1 | Controller arm bit for the read direction (falling edge arms) |
| ctl_odata_we | input | 1 | Load strobe for the output data register |
| ctl_odata | input | DATA_W | Byte to load into the output data register |
| ctl_idata | output | DATA_W | Input data register, last byte written by the host |
| irq_wr_done | output | 1 | One-clock pulse when a host write completes |
| irq_rd_done | output | 1 | One-clock pulse when a host read completes |

## Verification
The bench first checks that arming reacts only to the falling half of the control pulse. A design that armed on the rising half, or on the level, would pull a flag low while the bit is still held high. It then sends strobes to unarmed directions and to the wrong direction. A design that does not gate on the flag would latch stray bytes, fire spurious interrupts or drive the bus into a host that is not reading. Interrupt pulses are counted over a window, so a pulse that stretches or repeats shows up as a wrong count. Payloads include all-zero and all-one bytes, so a latch that misses or sticks is caught. A reset in the middle of an armed cycle must leave both flags high.

// File: rtl/hsp_pkg.sv
package hsp_pkg;
  localparam int DATA_W_DEF = 8;
  localparam int SYNC_STAGES_DEF = 2;

  typedef enum logic {
    DIR_WRITE = 1'b0,
    DIR_READ  = 1'b1
  } hsp_dir_e;
endpackage

// File: rtl/hsp_sync.sv
module hsp_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= RST_VAL;
    else     chain[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[i] <= RST_VAL;
      else     chain[i] <= chain[i-1];
    end
  end

  assign q = chain[LAST];
endmodule

// File: rtl/hsp_channel.sv
module hsp_channel #(
  parameter hsp_pkg::hsp_dir_e DIR = hsp_pkg::DIR_WRITE
) (
  input  logic clk,
  input  logic rst,
  input  logic arm_lvl,
  input  logic stb_rise,
  input  logic rnw_s,
  output logic rdy_n,
  output logic accept,
  output logic done_irq
);
  logic arm_prev;
  logic arm_fall;
  logic dir_match;

  // follows the arm bit even in reset so edge detection is valid at once
  always_ff @(posedge clk) arm_prev <= arm_lvl;

  assign arm_fall  = arm_prev & ~arm_lvl;
  assign dir_match = (rnw_s == logic'(DIR));
  // a new arm edge wins over a completion in the same clock
  assign accept    = stb_rise & dir_match & ~rdy_n & ~arm_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_n    <= 1'b1;
      done_irq <= 1'b0;
    end else begin
      done_irq <= accept;
      if (arm_fall)    rdy_n <= 1'b0;
      else if (accept) rdy_n <= 1'b1;
    end
  end

  // R2: falling arm edge leaves the flag armed
  a_r2_arm_on_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(arm_lvl) |=> !rdy_n);

  // R2: rising or held arm bit never pulls an idle flag low
  a_r2_no_arm_on_rise: assert property (@(posedge clk) disable iff (rst)
    (arm_lvl && rdy_n) |=> rdy_n);

  // R4: interrupt lasts one clock only
  a_r4_irq_single: assert property (@(posedge clk) disable iff (rst)
    done_irq |=> !done_irq);

  // R4: interrupt coincides with the flag returning high
  a_r4_irq_with_release: assert property (@(posedge clk) disable iff (rst)
    (done_irq && !$past(rst)) |-> (rdy_n && !$past(rdy_n)));

  // R7: a strobe into an unarmed direction is silent
  a_r7_unarmed_quiet: assert property (@(posedge clk) disable iff (rst)
    (stb_rise && rdy_n) |=> !done_irq);
endmodule

// File: rtl/host_slave_port.sv
module host_slave_port #(
  parameter int DATA_W = hsp_pkg::DATA_W_DEF,
  parameter int SYNC_STAGES = hsp_pkg::SYNC_STAGES_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] host_din,
  input  logic              host_rnw,
  input  logic              host_strobe,
  output logic [DATA_W-1:0] host_dout,
  output logic              host_dout_en,
  output logic              host_in_rdy_n,
  output logic              host_out_rdy_n,
  input  logic              ctl_arm_wr,
  input  logic              ctl_arm_rd,
  input  logic              ctl_odata_we,
  input  logic [DATA_W-1:0] ctl_odata,
  output logic [DATA_W-1:0] ctl_idata,
  output logic              irq_wr_done,
  output logic              irq_rd_done
);
  localparam int NDIR = 2;
  localparam int IDX_WR = int'(hsp_pkg::DIR_WRITE);
  localparam int IDX_RD = int'(hsp_pkg::DIR_READ);

  // bit 1: strobe (idle high), bit 0: read/write select
  logic [1:0] host_ctl_s;
  logic       stb_s, rnw_s, stb_d, stb_rise;

  hsp_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_sync (
    .clk(clk), .rst(rst),
    .d({host_strobe, host_rnw}),
    .q(host_ctl_s)
  );

  assign stb_s = host_ctl_s[1];
  assign rnw_s = host_ctl_s[0];

  always_ff @(posedge clk) begin
    if (rst) stb_d <= 1'b1;
    else     stb_d <= stb_s;
  end

  assign stb_rise = stb_s & ~stb_d;

  logic [NDIR-1:0] arm_vec, rdy_n_vec, accept_vec, irq_vec;

  assign arm_vec[IDX_WR] = ctl_arm_wr;
  assign arm_vec[IDX_RD] = ctl_arm_rd;

  for (genvar g = 0; g < NDIR; g++) begin : g_dir
    hsp_channel #(.DIR(hsp_pkg::hsp_dir_e'(g))) u_chan (
      .clk(clk), .rst(rst),
      .arm_lvl(arm_vec[g]),
      .stb_rise(stb_rise),
      .rnw_s(rnw_s),
      .rdy_n(rdy_n_vec[g]),
      .accept(accept_vec[g]),
      .done_irq(irq_vec[g])
    );
  end

  assign host_in_rdy_n  = rdy_n_vec[IDX_WR];
  assign host_out_rdy_n = rdy_n_vec[IDX_RD];
  assign irq_wr_done    = irq_vec[IDX_WR];
  assign irq_rd_done    = irq_vec[IDX_RD];

  logic [DATA_W-1:0] odata_q;
  logic              drive_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_idata <= '0;
      odata_q   <= '0;
    end else begin
      if (accept_vec[IDX_WR]) ctl_idata <= host_din;
      if (ctl_odata_we)       odata_q   <= ctl_odata;
    end
  end

  assign drive_next = rnw_s & ~stb_s & ~rdy_n_vec[IDX_RD];

  always_ff @(posedge clk) begin
    if (rst) begin
      host_dout_en <= 1'b0;
      host_dout    <= '0;
    end else begin
      host_dout_en <= drive_next;
      host_dout    <= drive_next ? odata_q : '0;
    end
  end

  // R3: the completed write stored the byte the host held on the bus
  a_r3_latch_on_done: assert property (@(posedge clk) disable iff (rst)
    (irq_wr_done && !$past(rst)) |-> (ctl_idata == $past(host_din)));

  // R9: input register only changes at a completed write
  a_r9_idata_hold: assert property (@(posedge clk) disable iff (rst)
    (!irq_wr_done && !$past(rst)) |-> $stable(ctl_idata));

  // R6: the bus is driven only for an armed read
  a_r6_drive_needs_arm: assert property (@(posedge clk) disable iff (rst)
    (host_dout_en && !$past(rst)) |-> !$past(host_out_rdy_n));

  // R5: read and write completions never coincide
  a_r5_irq_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(irq_wr_done && irq_rd_done));
endmodule

// File: tb/sim_host_slave_port.sv
module sim_host_slave_port;
  localparam int DW = 8;
  localparam int NVEC = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] host_din = '0;
  logic          host_rnw = 1'b0;
  logic          host_strobe = 1'b1;
  logic [DW-1:0] host_dout;
  logic          host_dout_en;
  logic          host_in_rdy_n, host_out_rdy_n;
  logic          ctl_arm_wr = 1'b0, ctl_arm_rd = 1'b0;
  logic          ctl_odata_we = 1'b0;
  logic [DW-1:0] ctl_odata = '0;
  logic [DW-1:0] ctl_idata;
  logic          irq_wr_done, irq_rd_done;

  int n_chk = 0;
  int n_bad = 0;
  logic [DW-1:0] exp_idata = '0;

  always #4 clk = ~clk;

  host_slave_port #(.DATA_W(DW)) u0 (
    .clk(clk), .rst(rst),
    .host_din(host_din), .host_rnw(host_rnw), .host_strobe(host_strobe),
    .host_dout(host_dout), .host_dout_en(host_dout_en),
    .host_in_rdy_n(host_in_rdy_n), .host_out_rdy_n(host_out_rdy_n),
    .ctl_arm_wr(ctl_arm_wr), .ctl_arm_rd(ctl_arm_rd),
    .ctl_odata_we(ctl_odata_we), .ctl_odata(ctl_odata),
    .ctl_idata(ctl_idata),
    .irq_wr_done(irq_wr_done), .irq_rd_done(irq_rd_done)
  );

  // op: 0 armed write, 1 armed read, 2 unarmed write, 3 unarmed read
  // fields: {op[1:0], host byte[7:0], output byte[7:0]}
  localparam logic [17:0] VEC [NVEC] = '{
    {2'd0, 8'hA5, 8'h00},
    {2'd1, 8'h00, 8'h3C},
    {2'd2, 8'h5A, 8'h00},
    {2'd0, 8'hFF, 8'h00},
    {2'd3, 8'h00, 8'h81},
    {2'd1, 8'h00, 8'hFF},
    {2'd0, 8'h00, 8'h00},
    {2'd2, 8'h11, 8'h00}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic arm(input logic rd);
    @(negedge clk);
    if (rd) ctl_arm_rd = 1'b1; else ctl_arm_wr = 1'b1;
    cycles(2);
    if (rd) ctl_arm_rd = 1'b0; else ctl_arm_wr = 1'b0;
    cycles(2);
  endtask

  task automatic load_out(input logic [DW-1:0] b);
    @(negedge clk);
    ctl_odata = b;
    ctl_odata_we = 1'b1;
    @(negedge clk);
    ctl_odata_we = 1'b0;
  endtask

  task automatic host_cycle(input logic rnw, input logic [DW-1:0] d,
                            output int nwr, output int nrd,
                            output logic en_low, output logic [DW-1:0] dout_low);
    @(negedge clk);
    host_rnw = rnw;
    host_din = d;
    cycles(3);
    host_strobe = 1'b0;
    cycles(4);
    en_low = host_dout_en;
    dout_low = host_dout;
    host_strobe = 1'b1;
    nwr = 0;
    nrd = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (irq_wr_done) nwr++;
      if (irq_rd_done) nrd++;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int nwr, nrd;
    logic en_low;
    logic [DW-1:0] dout_low;
    logic [1:0] op;
    logic [DW-1:0] hb, ob;

    cycles(3);
    rst = 1'b0;
    cycles(1);
    // R1 reset state
    chk("R1 in_rdy_n", 32'(host_in_rdy_n), 32'd1);
    chk("R1 out_rdy_n", 32'(host_out_rdy_n), 32'd1);
    chk("R1 irqs", 32'({irq_wr_done, irq_rd_done}), 32'd0);
    chk("R1 dout_en", 32'(host_dout_en), 32'd0);
    chk("R1 dout", 32'(host_dout), 32'd0);
    chk("R1 idata", 32'(ctl_idata), 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      op = VEC[i][17:16];
      hb = VEC[i][15:8];
      ob = VEC[i][7:0];
      if (op == 2'd1 || op == 2'd3) load_out(ob);
      if (op == 2'd0) begin
        arm(1'b0);
        chk("R2 write armed", 32'(host_in_rdy_n), 32'd0);
        host_cycle(1'b0, hb, nwr, nrd, en_low, dout_low);
        exp_idata = hb;
        chk("R3 idata latched", 32'(ctl_idata), 32'(exp_idata));
        chk("R3 in_rdy_n released", 32'(host_in_rdy_n), 32'd1);
        chk("R4 irq_wr pulses", 32'(nwr), 32'd1);
        chk("R4 no irq_rd", 32'(nrd), 32'd0);
      end else if (op == 2'd1) begin
        arm(1'b1);
        chk("R2 read armed", 32'(host_out_rdy_n), 32'd0);
        host_cycle(1'b1, 8'h00, nwr, nrd, en_low, dout_low);
        chk("R6 drive during read", 32'(en_low), 32'd1);
        chk("R6 read byte", 32'(dout_low), 32'(ob));
        chk("R5 out_rdy_n released", 32'(host_out_rdy_n), 32'd1);
        chk("R5 irq_rd pulses", 32'(nrd), 32'd1);
        chk("R5 no irq_wr", 32'(nwr), 32'd0);
        chk("R6 bus released", 32'(host_dout_en), 32'd0);
        chk("R9 idata kept over read", 32'(ctl_idata), 32'(exp_idata));
      end else begin
        host_cycle(op == 2'd3, hb, nwr, nrd, en_low, dout_low);
        chk("R7 unarmed irqs", 32'(nwr + nrd), 32'd0);
        chk("R7 unarmed flags", 32'({host_in_rdy_n, host_out_rdy_n}), 32'd3);
        chk("R7 unarmed no drive", 32'(en_low), 32'd0);
        chk("R9 idata kept over ignored", 32'(ctl_idata), 32'(exp_idata));
      end
    end

    // R2: rising half and held level must not arm
    @(negedge clk);
    ctl_arm_wr = 1'b1;
    cycles(4);
    chk("R2 held high no arm", 32'(host_in_rdy_n), 32'd1);
    ctl_arm_wr = 1'b0;
    cycles(2);
    chk("R2 fall arms", 32'(host_in_rdy_n), 32'd0);

    // R8: read strobe into an armed write is ignored, then write completes
    host_cycle(1'b1, 8'h77, nwr, nrd, en_low, dout_low);
    chk("R8 in_rdy_n still armed", 32'(host_in_rdy_n), 32'd0);
    chk("R8 no irqs", 32'(nwr + nrd), 32'd0);
    chk("R8 no drive", 32'(en_low), 32'd0);
    chk("R8 idata unchanged", 32'(ctl_idata), 32'(exp_idata));
    host_cycle(1'b0, 8'h3E, nwr, nrd, en_low, dout_low);
    exp_idata = 8'h3E;
    chk("R8 later write done", 32'(ctl_idata), 32'(exp_idata));
    chk("R8 later write irq", 32'(nwr), 32'd1);

    // R1: reset in the middle of an armed cycle
    arm(1'b0);
    arm(1'b1);
    @(negedge clk);
    rst = 1'b1;
    cycles(3);
    rst = 1'b0;
    cycles(1);
    chk("R1 mid-cycle in_rdy_n", 32'(host_in_rdy_n), 32'd1);
    chk("R1 mid-cycle out_rdy_n", 32'(host_out_rdy_n), 32'd1);
    chk("R1 mid-cycle idata", 32'(ctl_idata), 32'd0);

    cycles(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule